// File: doc/BRIEF.md
# Low-Power Handshake Responder

This block sits on the peripheral side of a four-phase power-down handshake for one clock domain. A clock controller lowers an active-low request line to ask the domain to let its clock stop. The responder then runs a preparation phase. It watches a local busy input until the domain has been quiet for a set number of consecutive cycles, or until a timeout runs out. It then publishes its verdict on an activity line and, one cycle later, lowers the active-low acknowledge.

A low activity line at acknowledge time means the power-down is accepted. A high line means it is refused and the clock must keep running. The controller ends the exchange by raising the request again, and the responder answers by raising acknowledge. This return phase runs whether the request was accepted or refused. A request that is withdrawn before acknowledge falls is dropped without any acknowledge. One instance is placed per clock domain.

Top module: `lph_responder`

## Requirements
- R1: While reset is held and on the first cycle after it, the acknowledge output is high and the activity output is high.
- R2: While no handshake is in progress, acknowledge stays high and the activity output equals the busy input as sampled at the previous clock edge.
- R3: After the request falls, the activity output is high during preparation. When busy has been sampled low on IDLE_CYCLES consecutive preparation edges, the activity output goes low (accept).
- R4: If TIMEOUT_CYCLES preparation edges pass without meeting the condition in R3, the activity output stays high as a refusal.
- R5: If the idle condition and the timeout are both met on the same edge, the request is accepted.
- R6: Acknowledge falls exactly one edge after the verdict is placed on the activity output. The activity output does not change while acknowledge stays low.
- R7: If the request goes high during preparation, or on the edge where the verdict is held, the block returns to the idle state. Acknowledge is not lowered, and the activity output again follows busy.
- R8: While acknowledge is low, a high request raises acknowledge on the next edge, for accepted and refused requests alike. The block then behaves as in R2.
- R9: Acknowledge only falls when the request was low on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Domain clock |
| rst | input | 1 | Synchronous reset, active high |
| lp_req_n_i | input | 1 | Power-down request from the clock controller, active low |
| busy_i | input | 1 | High while the rest of the domain has work in flight |
| lp_ack_n_o | output | 1 | Handshake acknowledge, active low |
| lp_active_o | output | 1 | Verdict and activity: low means the clock may stop |

## Verification
The bench builds the block with IDLE_CYCLES = 3 and TIMEOUT_CYCLES = 8. With these values both the accept path and the timeout refusal complete in a few cycles. They also allow a directed pattern in which busy is high for five preparation edges and then low for three, so that the idle condition and the timeout are met on the same edge. Random request and busy traffic then reaches cancellation during preparation and during the verdict-hold cycle, and refusals followed by wake-up, many times over.

// File: rtl/lph_pkg.sv
package lph_pkg;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PREP = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOW  = 2'd3
    } lph_state_e;

    typedef struct packed {
        logic decided;
        logic refuse;
    } lph_verdict_t;

    // The idle condition wins a tie with the timeout.
    function automatic lph_verdict_t lph_judge(input logic idle_met, input logic tmo_hit);
        lph_verdict_t v;
        v.decided = idle_met | tmo_hit;
        v.refuse  = tmo_hit & ~idle_met;
        return v;
    endfunction

endpackage

// File: rtl/lph_idle_qual.sv
module lph_idle_qual #(
    parameter int IDLE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic busy_i,
    output logic met_o
);
    localparam int CW = $clog2(IDLE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic [CW-1:0] quiet_q;

    assign met_o = run_i & ~busy_i & (quiet_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i || busy_i) begin
            quiet_q <= '0;
        end else if (quiet_q != LAST) begin
            quiet_q <= quiet_q + 1'b1;
        end
    end

    // R3
    quiet_bound_chk: assert property (@(posedge clk) disable iff (rst)
        quiet_q <= LAST);

endmodule

// File: rtl/lph_timer.sv
module lph_timer #(
    parameter int TIMEOUT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic hit_o
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

    logic [TW-1:0] elapsed_q;

    assign hit_o = run_i & (elapsed_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            elapsed_q <= '0;
        end else if (elapsed_q != LAST) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    // R4
    timer_bound_chk: assert property (@(posedge clk) disable iff (rst)
        elapsed_q <= LAST);

endmodule

// File: rtl/lph_fsm.sv
module lph_fsm
    import lph_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req_n_i,
    input  logic busy_i,
    input  logic idle_met_i,
    input  logic tmo_hit_i,
    output logic prep_o,
    output logic ack_n_o,
    output logic active_o
);
    lph_state_e   state_q;
    logic         ack_n_q;
    logic         active_q;
    lph_verdict_t verdict;

    assign verdict  = lph_judge(idle_met_i, tmo_hit_i);
    assign prep_o   = (state_q == ST_PREP);
    assign ack_n_o  = ack_n_q;
    assign active_o = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_RUN;
            ack_n_q  <= 1'b1;
            active_q <= 1'b1;
        end else begin
            case (state_q)
                ST_RUN: begin
                    ack_n_q <= 1'b1;
                    if (!req_n_i) begin
                        state_q  <= ST_PREP;
                        active_q <= 1'b1;
                    end else begin
                        active_q <= busy_i;
                    end
                end
                ST_PREP: begin
                    if (req_n_i) begin
                        state_q  <= ST_RUN;
                        active_q <= busy_i;
                    end else if (verdict.decided) begin
                        state_q  <= ST_HOLD;
                        active_q <= verdict.refuse;
                    end
                end
                ST_HOLD: begin
                    if (req_n_i) begin
                        state_q  <= ST_RUN;
                        active_q <= busy_i;
                    end else begin
                        state_q <= ST_LOW;
                        ack_n_q <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (req_n_i) begin
                        state_q  <= ST_RUN;
                        ack_n_q  <= 1'b1;
                        active_q <= busy_i;
                    end
                end
                default: state_q <= ST_RUN;
            endcase
        end
    end

    // R7
    cancel_prep_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_PREP && req_n_i) |=> (state_q == ST_RUN && ack_n_q));

endmodule

// File: rtl/lph_responder.sv
module lph_responder #(
    parameter int IDLE_CYCLES    = 4,
    parameter int TIMEOUT_CYCLES = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic lp_req_n_i,
    input  logic busy_i,
    output logic lp_ack_n_o,
    output logic lp_active_o
);
    logic prep;
    logic idle_met;
    logic tmo_hit;

    lph_idle_qual #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk    (clk),
        .rst    (rst),
        .run_i  (prep),
        .busy_i (busy_i),
        .met_o  (idle_met)
    );

    lph_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run_i (prep),
        .hit_o (tmo_hit)
    );

    lph_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_n_i    (lp_req_n_i),
        .busy_i     (busy_i),
        .idle_met_i (idle_met),
        .tmo_hit_i  (tmo_hit),
        .prep_o     (prep),
        .ack_n_o    (lp_ack_n_o),
        .active_o   (lp_active_o)
    );

    // R6
    verdict_lead_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lp_ack_n_o) |-> $stable(lp_active_o));

    // R6
    verdict_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lp_ack_n_o && $past(!lp_ack_n_o)) |-> $stable(lp_active_o));

    // R8
    wake_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!lp_ack_n_o && lp_req_n_i) |=> lp_ack_n_o);

    // R9
    ack_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(lp_ack_n_o) |-> $past(!lp_req_n_i));

endmodule

// File: tb/lph_responder_test.sv
module lph_responder_test;
    localparam int IDLE = 3;
    localparam int TMO  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_n = 1'b1;
    logic busy = 1'b1;
    logic ack_n;
    logic active;

    int checks = 0;
    int failures = 0;

    // Reference model state: 0 idle, 1 prep, 2 hold, 3 ack low
    int   m_st = 0;
    int   m_ic = 0;
    int   m_tc = 0;
    logic e_ack = 1'b1;
    logic e_act = 1'b1;
    string m_tag = "R1";

    always #2.5 clk = ~clk;

    lph_responder #(.IDLE_CYCLES(IDLE), .TIMEOUT_CYCLES(TMO)) uut (
        .clk         (clk),
        .rst         (rst),
        .lp_req_n_i  (req_n),
        .busy_i      (busy),
        .lp_ack_n_o  (ack_n),
        .lp_active_o (active)
    );

    task automatic check(input string tag, input string what, input logic act_v, input logic exp_v);
        checks++;
        if (act_v !== exp_v) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act_v, exp_v, $time);
        end
    endtask

    // Next expected outputs, derived from the requirements
    task automatic model(input logic rq, input logic bz);
        case (m_st)
            0: begin
                e_ack = 1'b1;
                m_tag = "R2";
                if (!rq) begin
                    m_st = 1; e_act = 1'b1; m_ic = 0; m_tc = 0;
                end else begin
                    e_act = bz;
                end
            end
            1: begin
                if (rq) begin
                    m_st = 0; e_act = bz; m_tag = "R7";
                end else begin
                    m_ic = bz ? 0 : m_ic + 1;
                    m_tc = m_tc + 1;
                    if (m_ic >= IDLE) begin
                        m_st = 2; e_act = 1'b0;
                        m_tag = (m_tc >= TMO) ? "R5" : "R3";
                    end else if (m_tc >= TMO) begin
                        m_st = 2; e_act = 1'b1; m_tag = "R4";
                    end else begin
                        m_tag = "R3";
                    end
                end
            end
            2: begin
                if (rq) begin
                    m_st = 0; e_act = bz; m_tag = "R7";
                end else begin
                    m_st = 3; e_ack = 1'b0; m_tag = "R6";
                end
            end
            default: begin
                if (rq) begin
                    m_st = 0; e_ack = 1'b1; e_act = bz; m_tag = "R8";
                end else begin
                    m_tag = "R6";
                end
            end
        endcase
    endtask

    // One cycle: inputs driven at the falling edge, outputs checked at the next falling edge
    task automatic cyc(input logic rq, input logic bz);
        req_n = rq;
        busy  = bz;
        model(rq, bz);
        @(negedge clk);
        check(m_tag, "ack", ack_n, e_ack);
        check(m_tag, "active", active, e_act);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1", "ack in reset", ack_n, 1'b1);
        check("R1", "active in reset", active, 1'b1);
        rst = 1'b0;
        req_n = 1'b1;
        busy = 1'b0;
        @(negedge clk);
        // R1: first edge after reset, active shows busy sampled (low)
        e_act = 1'b0;
        check("R1", "ack after reset", ack_n, 1'b1);
        check("R2", "active follows busy", active, 1'b0);

        // R2: idle tracking
        cyc(1, 1); cyc(1, 0); cyc(1, 1); cyc(1, 1);

        // R3: quiet domain, accept after IDLE edges
        cyc(0, 0);
        for (int i = 0; i < IDLE; i++) cyc(0, 0);
        check("R3", "accept verdict", active, 1'b0);
        check("R6", "ack still high at verdict", ack_n, 1'b1);
        cyc(0, 1);
        check("R6", "ack low one edge later", ack_n, 1'b0);
        cyc(0, 1); cyc(0, 0);
        check("R6", "verdict held", active, 1'b0);
        cyc(1, 1);
        check("R8", "ack raised after accept", ack_n, 1'b1);
        cyc(1, 0); cyc(1, 1);

        // R4: busy domain, refusal by timeout, then wake
        cyc(0, 1);
        for (int i = 0; i < TMO; i++) cyc(0, 1);
        check("R4", "refusal verdict", active, 1'b1);
        cyc(0, 0);
        check("R4", "ack low on refusal", ack_n, 1'b0);
        cyc(0, 0);
        check("R6", "refusal held", active, 1'b1);
        cyc(1, 0);
        check("R8", "ack raised after refusal", ack_n, 1'b1);
        cyc(1, 0);

        // R5: idle condition lands on the timeout edge
        cyc(0, 1);
        for (int i = 0; i < TMO - IDLE; i++) cyc(0, 1);
        for (int i = 0; i < IDLE; i++) cyc(0, 0);
        check("R5", "tie accepted", active, 1'b0);
        cyc(0, 1); cyc(1, 1); cyc(1, 1);

        // R7: cancel during preparation
        cyc(0, 0); cyc(0, 0); cyc(1, 1);
        check("R7", "cancel in prep, ack high", ack_n, 1'b1);
        check("R7", "cancel in prep, active follows busy", active, 1'b1);
        cyc(1, 0);

        // R7: cancel on the verdict-hold edge
        cyc(0, 0);
        for (int i = 0; i < IDLE; i++) cyc(0, 0);
        cyc(1, 0);
        check("R7", "cancel in hold, ack high", ack_n, 1'b1);
        check("R7", "cancel in hold, active follows busy", active, 1'b0);
        cyc(1, 1);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            logic rq;
            logic bz;
            rq = ($urandom_range(0, 11) == 0) ? ~req_n : req_n;
            bz = ($urandom_range(0, 9) < 4);
            cyc(rq, bz);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule